// File: doc/BRIEF.md
# Video Memory Transfer Engine

This block moves 16-bit words into one of the video memories without involving the processor. It runs three kinds of transfer. The first reads words from system memory over a simple request/acknowledge read bus. The second writes one constant word repeatedly. The third copies words from one place in VRAM to another. A command decoder upstream supplies the start pulse, the destination address and the target-memory select. A register file supplies the length, the source address, the operation field and the auto-increment step.

A fill is not launched by the start pulse alone. The start pulse arms the engine, and the next data-port write delivers the fill word and starts the writes. That data-port write is consumed by the engine and is flagged back so the normal data path can drop it. Every word leaves through a byte-wide video write port in two consecutive cycles. When the transfer ends, the engine pulses an advance request carrying the amount by which the command address must move.

The controller has eight states:
- IDLE: waits for a start.
- ARMED: a fill waiting for its word.
- BUS_RD: a system-bus request awaiting acknowledge.
- VR_ADDR and VR_DATA: a VRAM read address cycle, then its data cycle.
- PUT_HI and PUT_LO: the two byte writes of one word.
- DONE: the one-cycle completion pulse.

Transitions:
- IDLE to BUS_RD, ARMED, VR_ADDR or DONE on an accepted start, by operation. A zero length goes straight to DONE, except for a fill, which still arms.
- ARMED to PUT_HI, or to DONE for a zero length, on a data-port write.
- BUS_RD to PUT_HI on acknowledge.
- VR_ADDR to VR_DATA to PUT_HI.
- PUT_HI to PUT_LO.
- PUT_LO to DONE on the last word. Otherwise PUT_LO goes back to the fetch state of the operation, or to PUT_HI for a fill.
- DONE to IDLE.

Top module: `vdma_engine`

## Requirements
- R1: After reset, busy_o, bus_req_o, vr_en_o, vw_en_o, adv_o and fill_take_o are all low.
- R2: The operation comes from src_hi_i[7:6] at the accepted start: 0 or 1 selects system memory to video memory, 2 selects fill, 3 selects copy within VRAM.
- R3: For a system-memory transfer, word k is requested at bus_addr_o = {src_hi_i[5:0], src_mid_i, src_lo_i} + 2k. bus_req_o stays high with a stable address until bus_ack_i, and bus_data_i is taken in the acknowledge cycle.
- R4: Word k is written at destination dest_addr_i + k*incr_i (16-bit wrap), with vw_sel_o equal to the target_sel_i captured at start.
- R5: Each word is stored big-endian. Bits 15:8 are written at the word's destination, and bits 7:0 at destination + 1 in the following cycle.
- R6: The number of words transferred is ceil(L/2), where L = {len_hi_i, len_lo_i}; the loop ends once the byte count reaches or passes L. L = 0 writes nothing.
- R7: A fill writes nothing until data_wr_i. While armed, that write's data_i becomes the fill word, and fill_take_o is high in that cycle. A data_wr_i while not armed has no effect on the engine.
- R8: A VRAM copy reads word k at vr_addr_o = {src_mid_i, src_lo_i} + 2k, and takes vr_data_i in the cycle after vr_en_o.
- R9: On completion, adv_o is high for exactly one cycle. adv_amt_o is (L * incr_i / 2) modulo 2^16.
- R10: busy_o is high from the cycle after an accepted start through the adv_o cycle. A start_i while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from the command decoder |
| dest_addr_i | input | 16 | Destination byte address |
| target_sel_i | input | 2 | Target video memory select |
| len_lo_i | input | 8 | Length, low byte |
| len_hi_i | input | 8 | Length, high byte |
| src_lo_i | input | 8 | Source address, low byte |
| src_mid_i | input | 8 | Source address, middle byte |
| src_hi_i | input | 8 | Operation field [7:6], source high bits [5:0] |
| incr_i | input | 8 | Destination step per word |
| data_wr_i | input | 1 | Data-port write strobe |
| data_i | input | 16 | Data-port write value |
| fill_take_o | output | 1 | Data-port write consumed as fill word |
| bus_req_o | output | 1 | System-bus read request |
| bus_addr_o | output | 22 | System-bus byte address |
| bus_ack_i | input | 1 | System-bus acknowledge, data valid |
| bus_data_i | input | 16 | System-bus read data |
| vr_en_o | output | 1 | VRAM read enable |
| vr_addr_o | output | 16 | VRAM read address |
| vr_data_i | input | 16 | VRAM read word, one cycle after enable |
| vw_en_o | output | 1 | Video memory byte write enable |
| vw_sel_o | output | 2 | Video memory select for the write |
| vw_addr_o | output | 16 | Video memory byte write address |
| vw_byte_o | output | 8 | Video memory byte write data |
| busy_o | output | 1 | Transfer armed or in progress |
| adv_o | output | 1 | Command address advance pulse |
| adv_amt_o | output | 16 | Amount of the command address advance |

## Verification
System-memory transfers use both encodings of that operation, an even and an odd length, and source addresses with nonzero high bits. Together they separate the word-count rule, the carry into the upper source bits and the operation decode. A fill is held armed for several idle cycles and then given its word. This shows the start alone writes nothing, while the data write both starts the fill and gets flagged. Its one-byte increment makes consecutive words overlap, which exposes any swap of the byte order. A VRAM copy, a zero-length start and a second start issued mid-transfer with different settings show the read path, the empty loop and the ignoring of starts while busy.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUS_RD,
        ST_VR_ADDR,
        ST_VR_DATA,
        ST_PUT_HI,
        ST_PUT_LO,
        ST_DONE
    } vdma_state_e;

    typedef enum logic [1:0] {
        OP_SYS2VID,
        OP_FILL,
        OP_VCOPY
    } vdma_op_e;

    function automatic vdma_op_e decode_op(input logic [1:0] field);
        vdma_op_e op;
        unique case (field)
            2'b10:   op = OP_FILL;
            2'b11:   op = OP_VCOPY;
            default: op = OP_SYS2VID;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/vdma_cfg_latch.sv
module vdma_cfg_latch
    import vdma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int INC_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic [INC_W-1:0] incr_in,
    input  logic [SEL_W-1:0] sel_in,
    input  vdma_op_e         op_in,
    output logic [LEN_W-1:0] len_q,
    output logic [INC_W-1:0] incr_q,
    output logic [SEL_W-1:0] sel_q,
    output vdma_op_e         op_q,
    output logic             zero_q,
    output logic [LEN_W-1:0] adv_amt
);
    localparam int PROD_W = LEN_W + INC_W;

    logic [PROD_W-1:0] prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            incr_q <= '0;
            sel_q  <= '0;
            op_q   <= OP_SYS2VID;
            zero_q <= 1'b1;
        end else if (load) begin
            len_q  <= len_in;
            incr_q <= incr_in;
            sel_q  <= sel_in;
            op_q   <= op_in;
            zero_q <= (len_in == '0);
        end
    end

    always_comb begin
        prod    = PROD_W'(len_q) * PROD_W'(incr_q);
        adv_amt = prod[LEN_W:1];
    end
endmodule

// File: rtl/vdma_datapath.sv
module vdma_datapath #(
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8,
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_word,
    input  logic [SRC_W-1:0]  src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [INC_W-1:0]  incr_q,
    input  logic [LEN_W-1:0]  len_q,
    output logic [SRC_W-1:0]  src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [DATA_W-1:0] word_q,
    output logic              last_word
);
    localparam int CNT_W = LEN_W + 1;
    localparam int BYTES_PER_WORD = DATA_W / 8;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt   = cnt_q + CNT_W'(BYTES_PER_WORD);
    assign last_word = (cnt_nxt >= {1'b0, len_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            src_q <= src_in;
            dst_q <= dst_in;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            src_q <= src_q + SRC_W'(BYTES_PER_WORD);
            dst_q <= dst_q + ADDR_W'(incr_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (cap_en) word_q <= cap_word;
    end
endmodule

// File: rtl/vdma_fsm.sv
module vdma_fsm
    import vdma_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  vdma_op_e op_in,
    input  logic     zero_in,
    input  vdma_op_e op_q,
    input  logic     zero_q,
    input  logic     data_wr_i,
    input  logic     bus_ack_i,
    input  logic     last_word,
    output logic     load,
    output logic     step,
    output logic     cap_bus,
    output logic     cap_vr,
    output logic     cap_fill,
    output logic     bus_req,
    output logic     vr_en,
    output logic     vw_en,
    output logic     byte_hi,
    output logic     adv,
    output logic     busy
);
    vdma_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_in == OP_FILL) state_d = ST_ARMED;
                    else if (zero_in)     state_d = ST_DONE;
                    else if (op_in == OP_VCOPY) state_d = ST_VR_ADDR;
                    else                  state_d = ST_BUS_RD;
                end
            end
            ST_ARMED:   if (data_wr_i) state_d = zero_q ? ST_DONE : ST_PUT_HI;
            ST_BUS_RD:  if (bus_ack_i) state_d = ST_PUT_HI;
            ST_VR_ADDR: state_d = ST_VR_DATA;
            ST_VR_DATA: state_d = ST_PUT_HI;
            ST_PUT_HI:  state_d = ST_PUT_LO;
            ST_PUT_LO: begin
                if (last_word)            state_d = ST_DONE;
                else if (op_q == OP_FILL) state_d = ST_PUT_HI;
                else if (op_q == OP_VCOPY) state_d = ST_VR_ADDR;
                else                      state_d = ST_BUS_RD;
            end
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        cap_bus  = 1'b0;
        cap_vr   = 1'b0;
        cap_fill = 1'b0;
        bus_req  = 1'b0;
        vr_en    = 1'b0;
        vw_en    = 1'b0;
        byte_hi  = 1'b0;
        adv      = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start_i;
            end
            ST_ARMED:   cap_fill = data_wr_i;
            ST_BUS_RD: begin
                bus_req = 1'b1;
                cap_bus = bus_ack_i;
            end
            ST_VR_ADDR: vr_en = 1'b1;
            ST_VR_DATA: cap_vr = 1'b1;
            ST_PUT_HI: begin
                vw_en   = 1'b1;
                byte_hi = 1'b1;
            end
            ST_PUT_LO: begin
                vw_en = 1'b1;
                step  = 1'b1;
            end
            ST_DONE:    adv = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8,
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 22,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dest_addr_i,
    input  logic [SEL_W-1:0]  target_sel_i,
    input  logic [7:0]        len_lo_i,
    input  logic [7:0]        len_hi_i,
    input  logic [7:0]        src_lo_i,
    input  logic [7:0]        src_mid_i,
    input  logic [7:0]        src_hi_i,
    input  logic [INC_W-1:0]  incr_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              fill_take_o,
    output logic              bus_req_o,
    output logic [SRC_W-1:0]  bus_addr_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              vr_en_o,
    output logic [ADDR_W-1:0] vr_addr_o,
    input  logic [DATA_W-1:0] vr_data_i,
    output logic              vw_en_o,
    output logic [SEL_W-1:0]  vw_sel_o,
    output logic [ADDR_W-1:0] vw_addr_o,
    output logic [7:0]        vw_byte_o,
    output logic              busy_o,
    output logic              adv_o,
    output logic [LEN_W-1:0]  adv_amt_o
);
    localparam int HI_SRC_BITS = SRC_W - 16;

    vdma_op_e          op_in, op_q;
    logic              zero_in, zero_q;
    logic [LEN_W-1:0]  len_in, len_q;
    logic [INC_W-1:0]  incr_q;
    logic [SRC_W-1:0]  src_in, src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] word_q, cap_word;
    logic              load, step, cap_bus, cap_vr, cap_fill;
    logic              byte_hi, last_word;

    assign op_in   = decode_op(src_hi_i[7:6]);
    assign len_in  = LEN_W'({len_hi_i, len_lo_i});
    assign zero_in = (len_in == '0);
    // copy uses only the two low source bytes as a VRAM address
    assign src_in  = (op_in == OP_VCOPY)
                   ? SRC_W'({src_mid_i, src_lo_i})
                   : {src_hi_i[HI_SRC_BITS-1:0], src_mid_i, src_lo_i};

    always_comb begin
        unique case (1'b1)
            cap_bus:  cap_word = bus_data_i;
            cap_vr:   cap_word = vr_data_i;
            cap_fill: cap_word = data_i;
            default:  cap_word = word_q;
        endcase
    end

    vdma_cfg_latch #(.LEN_W(LEN_W), .INC_W(INC_W), .SEL_W(SEL_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .len_in(len_in), .incr_in(incr_i), .sel_in(target_sel_i), .op_in(op_in),
        .len_q(len_q), .incr_q(incr_q), .sel_q(vw_sel_o), .op_q(op_q),
        .zero_q(zero_q), .adv_amt(adv_amt_o)
    );

    vdma_datapath #(.LEN_W(LEN_W), .INC_W(INC_W), .ADDR_W(ADDR_W),
                    .SRC_W(SRC_W), .DATA_W(DATA_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .cap_en(cap_bus | cap_vr | cap_fill), .cap_word(cap_word),
        .src_in(src_in), .dst_in(dest_addr_i), .incr_q(incr_q), .len_q(len_q),
        .src_q(src_q), .dst_q(dst_q), .word_q(word_q), .last_word(last_word)
    );

    vdma_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_in(op_in), .zero_in(zero_in), .op_q(op_q), .zero_q(zero_q),
        .data_wr_i(data_wr_i), .bus_ack_i(bus_ack_i), .last_word(last_word),
        .load(load), .step(step), .cap_bus(cap_bus), .cap_vr(cap_vr),
        .cap_fill(cap_fill), .bus_req(bus_req_o), .vr_en(vr_en_o),
        .vw_en(vw_en_o), .byte_hi(byte_hi), .adv(adv_o), .busy(busy_o)
    );

    assign fill_take_o = cap_fill;
    assign bus_addr_o  = src_q;
    assign vr_addr_o   = src_q[ADDR_W-1:0];
    assign vw_addr_o   = byte_hi ? dst_q : dst_q + ADDR_W'(1);
    assign vw_byte_o   = byte_hi ? word_q[DATA_W-1:DATA_W-8] : word_q[7:0];
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8,
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 22,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              data_wr_i,
    input logic              fill_take_o,
    input logic              bus_req_o,
    input logic [SRC_W-1:0]  bus_addr_o,
    input logic              bus_ack_i,
    input logic              vr_en_o,
    input logic              vw_en_o,
    input logic [ADDR_W-1:0] vw_addr_o,
    input logic              busy_o,
    input logic              adv_o
);
    // R1
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !vw_en_o && !bus_req_o && !vr_en_o && !adv_o);
    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o));
    // R5
    lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vw_en_o && !$past(vw_en_o) |=> vw_en_o && vw_addr_o == $past(vw_addr_o) + ADDR_W'(1));
    // R7
    fill_take_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take_o |-> busy_o && data_wr_i && !vw_en_o);
    // R9
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> !adv_o && !busy_o);
    // R10
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> !busy_o);
    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req_o, vr_en_o, vw_en_o, adv_o}));
endmodule

bind vdma_engine vdma_engine_chk #(
    .LEN_W(LEN_W), .INC_W(INC_W), .ADDR_W(ADDR_W),
    .SRC_W(SRC_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/vdma_engine_tb_top.sv
module vdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] dest_addr_i = '0;
    logic [1:0]  target_sel_i = '0;
    logic [7:0]  len_lo_i = '0, len_hi_i = '0, src_lo_i = '0, src_mid_i = '0, src_hi_i = '0;
    logic [7:0]  incr_i = '0;
    logic        data_wr_i = 1'b0;
    logic [15:0] data_i = '0;
    logic        fill_take_o, bus_req_o, bus_ack_i = 1'b0, vr_en_o, vw_en_o, busy_o, adv_o;
    logic [21:0] bus_addr_o;
    logic [15:0] bus_data_i = '0, vr_addr_o, vr_data_i = '0, vw_addr_o, adv_amt_o;
    logic [1:0]  vw_sel_o;
    logic [7:0]  vw_byte_o;

    int checks = 0;
    int fails = 0;
    int req_age = 0;
    int cycles = 0;

    logic [15:0] exp_wa[$];
    logic [7:0]  exp_wb[$];
    logic [1:0]  exp_ws[$];
    logic [21:0] exp_ba[$];
    logic [15:0] exp_va[$];

    vdma_engine dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] f_bus(input logic [21:0] a);
        return a[15:0] ^ {a[21:16], 10'h0} ^ 16'h5A0F;
    endfunction

    function automatic logic [15:0] f_vr(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responders and per-clock comparison against the queued model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (vw_en_o) begin
                if (exp_wa.size() == 0) chk("R6 unexpected write", 1, 0);
                else begin
                    chk("R4 write address", vw_addr_o, exp_wa.pop_front());
                    chk("R5 write byte", vw_byte_o, exp_wb.pop_front());
                    chk("R4 write select", vw_sel_o, exp_ws.pop_front());
                end
            end
            if (bus_req_o) begin
                if (req_age == 1) begin
                    if (exp_ba.size() == 0) chk("R3 unexpected request", 1, 0);
                    else chk("R3 bus address", bus_addr_o, exp_ba.pop_front());
                    bus_ack_i  <= 1'b1;
                    bus_data_i <= f_bus(bus_addr_o);
                    req_age = 0;
                end else begin
                    bus_ack_i <= 1'b0;
                    req_age++;
                end
            end else begin
                bus_ack_i <= 1'b0;
                req_age = 0;
            end
            if (vr_en_o) begin
                if (exp_va.size() == 0) chk("R8 unexpected read", 1, 0);
                else chk("R8 read address", vr_addr_o, exp_va.pop_front());
                vr_data_i <= f_vr(vr_addr_o);
            end
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic push_word(input logic [15:0] dst, input logic [15:0] w, input logic [1:0] sel);
        exp_wa.push_back(dst);        exp_wb.push_back(w[15:8]); exp_ws.push_back(sel);
        exp_wa.push_back(dst + 16'd1); exp_wb.push_back(w[7:0]);  exp_ws.push_back(sel);
    endtask

    // model: queue the expected traffic of a transfer (fill words queued later)
    task automatic model(input logic [1:0] opf, input logic [15:0] dst, input logic [1:0] sel,
                         input logic [15:0] len, input logic [21:0] src, input logic [7:0] inc);
        int nw = (int'(len) + 1) / 2;
        for (int k = 0; k < nw; k++) begin
            logic [15:0] d = dst + 16'(k * int'(inc));
            if (opf == 2'd3) begin
                exp_va.push_back(src[15:0] + 16'(2*k));
                push_word(d, f_vr(src[15:0] + 16'(2*k)), sel);
            end else if (opf != 2'd2) begin
                exp_ba.push_back(src + 22'(2*k));
                push_word(d, f_bus(src + 22'(2*k)), sel);
            end
        end
    endtask

    task automatic start(input logic [1:0] opf, input logic [15:0] dst, input logic [1:0] sel,
                         input logic [15:0] len, input logic [21:0] src, input logic [7:0] inc,
                         input bit do_model);
        dest_addr_i = dst; target_sel_i = sel; len_lo_i = len[7:0]; len_hi_i = len[15:8];
        src_lo_i = src[7:0]; src_mid_i = src[15:8]; src_hi_i = {opf, src[21:16]};
        incr_i = inc; start_i = 1'b1;
        if (do_model) model(opf, dst, sel, len, src, inc);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req, input logic [15:0] amt);
        int n = 0;
        while (!adv_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " advance pulse"}, adv_o, 1);
        chk({req, " advance amount"}, adv_amt_o, amt);
        @(negedge clk);
        chk("R9 single pulse", adv_o, 0);
        chk("R10 busy cleared", busy_o, 0);
        chk("R6 all writes done", exp_wa.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 outputs", {bus_req_o, vr_en_o, vw_en_o, adv_o, fill_take_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 op 0, even length, high source bits
        start(2'd0, 16'h1000, 2'd0, 16'd6, 22'h2A_FFFC, 8'd2, 1);
        chk("R10 busy after start", busy_o, 1);
        wait_done("R9", 16'd6);

        // R2 R6 op 1, odd length, step 4, CRAM select
        start(2'd1, 16'h0040, 2'd1, 16'd3, 22'h01_2340, 8'd4, 1);
        wait_done("R6", 16'd6);

        // R7 data write while idle: no effect
        data_wr_i = 1'b1; data_i = 16'h1234;
        #1 chk("R7 idle data write ignored", fill_take_o, 0);
        @(negedge clk);
        data_wr_i = 1'b0;
        chk("R7 idle stays idle", busy_o, 0);

        // R7 fill armed, overlapping words with step 1
        start(2'd2, 16'h2000, 2'd0, 16'd4, 22'h0, 8'd1, 1);
        repeat (5) @(negedge clk);
        chk("R7 armed busy", busy_o, 1);
        chk("R7 armed no write", vw_en_o, 0);
        push_word(16'h2000, 16'hBEEF, 2'd0);
        push_word(16'h2001, 16'hBEEF, 2'd0);
        data_wr_i = 1'b1; data_i = 16'hBEEF;
        #1 chk("R7 fill take", fill_take_o, 1);
        @(negedge clk);
        data_wr_i = 1'b0;
        wait_done("R7", 16'd2);

        // R8 VRAM copy, VSRAM-side select ignored for reads
        start(2'd3, 16'h3000, 2'd0, 16'd4, 22'h00_8122, 8'd2, 1);
        wait_done("R8", 16'd4);

        // R6 zero length
        start(2'd0, 16'h4000, 2'd0, 16'd0, 22'h10, 8'd2, 1);
        wait_done("R6 zero", 16'd0);

        // R10 start while busy ignored
        start(2'd0, 16'h5000, 2'd2, 16'd4, 22'h00_0100, 8'd2, 1);
        repeat (2) @(negedge clk);
        start(2'd2, 16'h6000, 2'd1, 16'd8, 22'h0, 8'd6, 0);
        wait_done("R10", 16'd4);
        chk("R10 not armed", busy_o, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule